// File: doc/BRIEF.md
# Accumulator-Clocked Noise Shift Register

This block is the noise source of a phase-accumulator oscillator. It holds a 23-bit pseudo-random shift register. The register does not advance on every clock. It steps once on each cycle where a chosen accumulator bit (bit 19 of the companion accumulator) goes from 0 to 1. Because of this, the noise pitch follows the oscillator frequency setting.

The oscillator drives that single accumulator bit into `acc_bit` on every clock. It also drives its test control into `hold`. The block remembers the previous value of the bit on its own and detects the rising edge. The block gives out two values, both taken from eight fixed, non-adjacent register bits. The first is a 12-bit noise sample, left-aligned. The second is an 8-bit readback of the same bits.

Top module: `noise_lfsr`

## Requirements
- R1: While `rst_n` is low the register loads 0x7FFFF8, and the remembered previous `acc_bit` is taken as 0. After reset `noise_out` is 0xFE0 and `noise_rd` is 0xFE.
- R2: The register shifts exactly once at a clock edge where `acc_bit` is 1, the value sampled at the previous edge was 0, and `hold` is 0.
- R3: A shift moves the register one place toward bit 22. The new bit 0 is old bit 22 XOR old bit 17.
- R4: At an edge where `acc_bit` stays at 0, stays at 1, or falls, the register keeps its value.
- R5: While `hold` is 1 the register keeps its value even when `acc_bit` rises. The previous-bit memory still follows `acc_bit`, so if `hold` is released while `acc_bit` stays 1, no shift occurs.
- R6: `noise_out` bits 11 down to 4 are register bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order. `noise_out` bits 3:0 are always 0.
- R7: `noise_rd` always equals `noise_out[11:4]`.
- R8: The register never holds the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Oscillator test control; freezes the register |
| acc_bit | input | 1 | Current value of the accumulator bit that clocks the noise |
| noise_out | output | 12 | Left-aligned noise sample |
| noise_rd | output | 8 | Readback of the eight selected register bits |

## Verification
Two events can land on the same edge. One is a rising `acc_bit`. The other is `hold`, which is either asserted at that edge or released at it while the bit stays high. The bench drives both orders. It forces a 0-to-1 transition during `hold`, and it drops `hold` at the exact edge where the bit is already high. In both cases it expects the sample to stay unchanged. It then checks that the next real 0-to-1 transition shifts exactly once. Around these cases, accumulator bit streams taken from several frequency steps and from random values test that the shift count matches the rising-edge count.

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int          LFSR_W = 23,
  parameter int          TAP_HI = 22,
  parameter int          TAP_LO = 17,
  parameter int          OUT_W  = 12,
  parameter int          SEL_N  = 8,
  parameter logic [22:0] SEED   = 23'h7FFFF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             acc_bit,
  output logic [OUT_W-1:0] noise_out,
  output logic [SEL_N-1:0] noise_rd
);
  localparam int PAD_W = OUT_W - SEL_N;
  localparam int SEL [SEL_N] = '{2, 4, 7, 11, 13, 16, 20, 22};

  logic [LFSR_W-1:0] lfsr;
  logic              prev_bit;
  logic              step;
  logic              fb;

  assign step = acc_bit & ~prev_bit & ~hold;
  assign fb   = lfsr[TAP_HI] ^ lfsr[TAP_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr     <= SEED[LFSR_W-1:0];
      prev_bit <= 1'b0;
    end else begin
      prev_bit <= acc_bit;
      if (step) lfsr <= {lfsr[LFSR_W-2:0], fb};
    end
  end

  for (genvar i = 0; i < SEL_N; i++) begin : g_pick
    assign noise_rd[i] = lfsr[SEL[i]];
  end

  assign noise_out = {noise_rd, {PAD_W{1'b0}}};

  a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bit && !prev_bit && !hold) |=> lfsr[LFSR_W-1:1] == $past(lfsr[LFSR_W-2:0]));
  a_r3_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bit && !prev_bit && !hold) |=> lfsr[0] == ($past(lfsr[TAP_HI]) ^ $past(lfsr[TAP_LO])));
  a_r4_no_edge_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_bit || prev_bit) |=> $stable(lfsr));
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(lfsr));
  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    noise_out[PAD_W-1:0] == '0);
  a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: tb/noise_lfsr_test.sv
`timescale 1ns/1ps
module noise_lfsr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0;
  logic acc_bit = 1'b0;
  logic [11:0] noise_out;
  logic [7:0]  noise_rd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [11:0] exp; string tag; } item_t;
  item_t q[$];

  logic [22:0] m_lfsr;
  logic        m_prev;

  always #2.5 clk = ~clk;

  noise_lfsr uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .acc_bit(acc_bit),
    .noise_out(noise_out), .noise_rd(noise_rd)
  );

  function automatic logic [11:0] pick(logic [22:0] r);
    return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2], 4'b0000};
  endfunction

  task automatic check(logic [11:0] exp, string tag);
    total++;
    if (noise_out !== exp) begin
      bad++;
      $display("FAIL %s noise_out actual=%h expected=%h", tag, noise_out, exp);
    end
    total++;
    if (noise_rd !== exp[11:4]) begin
      bad++;
      $display("FAIL R7 %s noise_rd actual=%h expected=%h", tag, noise_rd, exp[11:4]);
    end
  endtask

  task automatic drive(logic b, logic h, string tag);
    @(negedge clk);
    acc_bit = b;
    hold = h;
    if (b && !m_prev && !h)
      m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
    m_prev = b;
    q.push_back('{pick(m_lfsr), tag});
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.exp, it.tag);
    end
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] acc;
    m_lfsr = 23'h7FFFF8;
    m_prev = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(12'hFE0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R6: single rising edges step one at a time
    for (int i = 0; i < 30; i++) begin
      drive(1'b1, 1'b0, "R2 rise");
      drive(1'b1, 1'b0, "R4 steady high");
      drive(1'b0, 1'b0, "R4 fall");
    end

    // R5: rise during hold, then release while bit stays high
    drive(1'b1, 1'b1, "R5 rise under hold");
    drive(1'b1, 1'b0, "R5 release while high");
    drive(1'b0, 1'b0, "R4 fall");
    drive(1'b1, 1'b0, "R2 rise after hold");
    drive(1'b0, 1'b1, "R5 fall under hold");
    drive(1'b1, 1'b1, "R5 rise under hold 2");
    drive(1'b1, 1'b1, "R5 hold high");
    drive(1'b0, 1'b1, "R5 hold fall");
    drive(1'b1, 1'b0, "R5 rise at release");

    // R2 R3 R6 R8: accumulator bit 19 over several frequencies
    foreach (acc[i]) acc[i] = 1'b0;
    for (int f = 0; f < 4; f++) begin
      int unsigned step_sz;
      step_sz = (f == 0) ? 24'h10000 : (f == 1) ? 24'h3F000 : (f == 2) ? 24'h7FFFF : 24'hC1234;
      for (int c = 0; c < 400; c++) begin
        acc = acc + step_sz[23:0];
        drive(acc[19], 1'b0, "R3 accumulator run");
      end
    end

    // random bit and hold patterns
    for (int c = 0; c < 1500; c++)
      drive(1'($urandom), ($urandom % 5) == 0, "R2 random");

    // R1: reset again mid-run
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    rst_n = 1'b0;
    acc_bit = 1'b0;
    hold = 1'b0;
    @(posedge clk);
    #1;
    check(12'hFE0, "R1 second reset");
    @(negedge clk);
    rst_n = 1'b1;
    m_lfsr = 23'h7FFFF8;
    m_prev = 1'b0;
    drive(1'b1, 1'b0, "R1 prev zero after reset");
    drive(1'b0, 1'b0, "R4 fall");

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule